// File: doc/BRIEF.md
# Serial Output-Freeze Controller

This block lets a slow two-wire serial link stop or release each of twelve divided output clocks. A frame opens with a low start bit and carries twelve mask bits, one per serial clock period, each sampled on a rising edge of the serial clock. A mask bit of 0 parks its output clock low and a 1 lets it run. The received mask is held back until the whole frame is in, and is then applied to all twelve outputs together.

Both serial lines are oversampled by the fast core clock through synchronizer flops, so the serial clock is never used as a clock. Each output clock has a gating cell. The cell brings the applied mask bit through its own two-flop synchronizer. It then changes its run state only while the raw clock is low. As a result, a frozen output always stops after a complete high pulse, and a released output always starts with a complete high pulse.

The raw clocks come from dividers outside this block. The outputs that can never be frozen do not pass through it.

Top module: `clk_freeze_ctrl`

## Requirements
- R1: While the receiver is idle, sampled serial bits of 1 are ignored. A sampled 0 on a rising serial clock edge starts a frame.
- R2: The n-th mask bit after the start bit (n = 0..11) controls `gated_clk_o[n]`. The indices 0..3 correspond to bank A outputs 0..3, 4..7 to bank B outputs 0..3, 8..10 to bank C outputs 1..3, and 11 to the sync output.
- R3: An applied mask bit of 0 holds its output low. A bit of 1 makes the output follow its raw clock, delayed by one core cycle.
- R4: The outputs keep the previous mask while a frame is partly received. They also keep it after the twelfth mask bit, until the next rising serial clock edge, which applies all twelve bits at once.
- R5: The bit sampled on the applying edge is the start bit of a new frame if it is 0. If it is 1, the receiver returns to idle and waits for a 0.
- R6: A freeze takes effect only at a falling edge of the raw clock. Every high pulse already started on an output completes at full width.
- R7: A release takes effect only at a rising edge of the raw clock. The first high pulse after release has full width.
- R8: After reset, every mask bit is 1 and the receiver is idle. Each output starts running from its first complete raw high pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; samples the serial lines and runs the gating cells |
| rst | input | 1 | Synchronous active-high reset |
| frz_sclk_i | input | 1 | Serial clock, at least 8 core cycles per half period |
| frz_sdata_i | input | 1 | Serial data, stable around each rising serial clock edge |
| raw_clk_i | input | MASK_W | Ungated divided clocks, synchronous to clk |
| gated_clk_o | output | MASK_W | Gated clocks, registered |

## Verification
The hardest case to reach is a partly received mask. It must stay invisible both during the frame and in the gap after the twelfth bit but before the applying edge. The stimulus sends eleven bits and pauses, then sends the twelfth bit and holds the serial clock low for a long time, checking the outputs at each point before it releases the applying edge. Frames are applied while the raw clocks of different periods sit at arbitrary phases. A pulse-width monitor on every output then shows that no truncated pulse appears. Back-to-back frames whose applying bit is 0 cover the case where the applying bit doubles as a start bit.

// File: rtl/frz_pkg.sv
package frz_pkg;
  localparam int FRZ_MASK_W = 12;
  localparam int FRZ_LINE_SYNC = 2;
  localparam int FRZ_CELL_SYNC = 2;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_SHIFT = 2'd1,
    RX_FULL  = 2'd2
  } rx_state_e;
endpackage

// File: rtl/frz_line_sampler.sv
module frz_line_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_i,
  input  logic sdata_i,
  output logic bit_stb_o,
  output logic bit_val_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] ck_sync;
  logic [STAGES-1:0] dt_sync;
  logic              ck_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_sync   <= '0;
      dt_sync   <= '1;
      ck_prev   <= 1'b0;
      bit_stb_o <= 1'b0;
      bit_val_o <= 1'b1;
    end else begin
      ck_sync   <= {ck_sync[STAGES-2:0], sclk_i};
      dt_sync   <= {dt_sync[STAGES-2:0], sdata_i};
      ck_prev   <= ck_sync[LAST];
      bit_stb_o <= ck_sync[LAST] & ~ck_prev;
      bit_val_o <= dt_sync[LAST];
    end
  end

  // R1: a serial edge yields one strobe, never two in a row
  stb_single_chk: assert property (@(posedge clk) disable iff (rst)
    bit_stb_o |=> !bit_stb_o);
endmodule

// File: rtl/frz_shift_rx.sv
module frz_shift_rx
  import frz_pkg::*;
#(
  parameter int MASK_W = FRZ_MASK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_stb_i,
  input  logic              bit_val_i,
  output logic [MASK_W-1:0] mask_o
);
  localparam int CNT_W = $clog2(MASK_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(MASK_W - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [MASK_W-1:0] shreg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      shreg_q <= '1;
      mask_o  <= '1;
    end else if (bit_stb_i) begin
      unique case (state_q)
        RX_IDLE: begin
          if (!bit_val_i) begin
            state_q <= RX_SHIFT;
            cnt_q   <= '0;
          end
        end
        RX_SHIFT: begin
          // first received bit lands at index 0 after MASK_W shifts
          shreg_q <= {bit_val_i, shreg_q[MASK_W-1:1]};
          cnt_q   <= cnt_q + 1'b1;
          if (cnt_q == LAST_BIT) state_q <= RX_FULL;
        end
        RX_FULL: begin
          mask_o  <= shreg_q;
          cnt_q   <= '0;
          state_q <= bit_val_i ? RX_IDLE : RX_SHIFT;
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  // R4
  mask_only_on_apply_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(mask_o) |-> ($past(state_q) == RX_FULL));

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == RX_SHIFT) |-> (cnt_q < CNT_W'(MASK_W)));

  // R5
  full_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == RX_FULL && bit_stb_i && !bit_val_i) |=>
      (state_q == RX_SHIFT && cnt_q == '0));
endmodule

// File: rtl/frz_gate_cell.sv
module frz_gate_cell #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run_req_i,
  input  logic raw_i,
  output logic clk_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] rq_sync;
  logic              run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rq_sync <= '1;
      run_q   <= 1'b0;
      clk_o   <= 1'b0;
    end else begin
      rq_sync <= {rq_sync[STAGES-2:0], run_req_i};
      if (!raw_i) run_q <= rq_sync[LAST];
      clk_o <= raw_i & run_q;
    end
  end

  // R6
  fall_on_raw_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_o) |-> !$past(raw_i));

  // R7
  rise_on_raw_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_o) |-> ($past(raw_i) && !$past(raw_i, 2)));

  // R3
  frozen_low_chk: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> !clk_o);
endmodule

// File: rtl/clk_freeze_ctrl.sv
module clk_freeze_ctrl
  import frz_pkg::*;
#(
  parameter int MASK_W     = FRZ_MASK_W,
  parameter int LINE_SYNC  = FRZ_LINE_SYNC,
  parameter int CELL_SYNC  = FRZ_CELL_SYNC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frz_sclk_i,
  input  logic              frz_sdata_i,
  input  logic [MASK_W-1:0] raw_clk_i,
  output logic [MASK_W-1:0] gated_clk_o
);
  logic              bit_stb;
  logic              bit_val;
  logic [MASK_W-1:0] mask;

  frz_line_sampler #(.STAGES(LINE_SYNC)) i_sampler (
    .clk       (clk),
    .rst       (rst),
    .sclk_i    (frz_sclk_i),
    .sdata_i   (frz_sdata_i),
    .bit_stb_o (bit_stb),
    .bit_val_o (bit_val)
  );

  frz_shift_rx #(.MASK_W(MASK_W)) i_rx (
    .clk       (clk),
    .rst       (rst),
    .bit_stb_i (bit_stb),
    .bit_val_i (bit_val),
    .mask_o    (mask)
  );

  for (genvar g = 0; g < MASK_W; g++) begin : g_cell
    frz_gate_cell #(.STAGES(CELL_SYNC)) i_cell (
      .clk       (clk),
      .rst       (rst),
      .run_req_i (mask[g]),
      .raw_i     (raw_clk_i[g]),
      .clk_o     (gated_clk_o[g])
    );
  end
endmodule

// File: tb/test_clk_freeze_ctrl.sv
`timescale 1ns/1ps
module test_clk_freeze_ctrl;
  localparam int N = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0;
  logic sdat = 1'b1;
  logic [N-1:0] raw = '0;
  logic [N-1:0] gated;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int rcnt [N];
  int hi_len [N];
  int runts [N];
  int pulses [N];

  // stimulus mask, expected running set
  localparam logic [23:0] VEC [6] = '{
    {12'h000, 12'h000}, {12'hFFF, 12'hFFF}, {12'h001, 12'h001},
    {12'h800, 12'h800}, {12'hA5C, 12'hA5C}, {12'h3F0, 12'h3F0}
  };

  always #2.5 clk = ~clk;

  clk_freeze_ctrl i_clk_freeze_ctrl (
    .clk         (clk),
    .rst         (rst),
    .frz_sclk_i  (sclk),
    .frz_sdata_i (sdat),
    .raw_clk_i   (raw),
    .gated_clk_o (gated)
  );

  function automatic int half_of(int i);
    return 2 + (i % 4);
  endfunction

  initial for (int i = 0; i < N; i++) begin
    rcnt[i] = 0; hi_len[i] = 0; runts[i] = 0; pulses[i] = 0;
  end

  // raw clock sources and pulse-width monitor
  always @(negedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (rcnt[i] == half_of(i) - 1) begin
        raw[i] <= ~raw[i];
        rcnt[i] = 0;
      end else rcnt[i] = rcnt[i] + 1;
      if (rst) hi_len[i] = 0;
      else if (gated[i]) hi_len[i] = hi_len[i] + 1;
      else if (hi_len[i] > 0) begin
        pulses[i] = pulses[i] + 1;
        if (hi_len[i] != half_of(i)) runts[i] = runts[i] + 1;
        hi_len[i] = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    sdat = b;
    repeat (10) @(negedge clk);
    sclk = 1'b1;
    repeat (10) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic send_mask(input logic [N-1:0] m);
    for (int i = 0; i < N; i++) send_bit(m[i]);
  endtask

  task automatic check_running(input string tag, input logic [N-1:0] exp);
    logic [N-1:0] seen;
    seen = '0;
    repeat (40) @(negedge clk);
    repeat (64) begin
      @(negedge clk);
      seen = seen | gated;
    end
    chk(seen == exp, tag, 32'(seen), 32'(exp));
  endtask

  initial begin
    repeat (10) @(negedge clk);
    chk(gated == '0, "R8 outputs low in reset", 32'(gated), 32'h0);
    rst = 1'b0;
    check_running("R8 all running after reset", 12'hFFF);

    // R1: idle ones ignored
    repeat (4) send_bit(1'b1);
    check_running("R1 idle ones ignored", 12'hFFF);

    // table walk: R3 level behaviour, R2 ordering on one-hot entries
    for (int k = 0; k < 6; k++) begin
      send_bit(1'b0);
      send_mask(VEC[k][23:12]);
      send_bit(1'b1);
      check_running((k == 2 || k == 3) ? "R2 bit order" : "R3 mask apply",
                    VEC[k][11:0]);
    end

    // R4: partial frame and pending frame stay invisible
    send_bit(1'b0);
    for (int i = 0; i < N - 1; i++) send_bit(1'b0);
    check_running("R4 after 11 bits", 12'h3F0);
    send_bit(1'b0);
    repeat (100) @(negedge clk);
    check_running("R4 after 12th bit, no apply edge", 12'h3F0);
    send_bit(1'b1);
    check_running("R4 applied on next edge", 12'h000);

    // R5: applying bit 0 doubles as the next start bit
    send_bit(1'b0);
    send_mask(12'h0F0);
    send_bit(1'b0);
    check_running("R5 first of back-to-back", 12'h0F0);
    send_mask(12'hF0F);
    check_running("R4 second frame pending", 12'h0F0);
    send_bit(1'b1);
    check_running("R5 second of back-to-back", 12'hF0F);
    repeat (3) send_bit(1'b1);
    check_running("R5 idle after applying 1", 12'hF0F);
    send_bit(1'b0);
    send_mask(12'hAAA);
    send_bit(1'b1);
    check_running("R5 restart after idle", 12'hAAA);

    // R6 R7: no truncated pulse on any output across all transitions
    for (int i = 0; i < N; i++) begin
      chk(runts[i] == 0 && pulses[i] > 0, "R6 R7 full-width pulses",
          32'(runts[i]), 32'h0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule